// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block connects a 16-bit core's memory request port to an external bus on which address and data share pins. For each accepted request it runs one bus cycle, or two when an 8-bit bus has to carry both bytes. Each cycle has an address phase with ALE high, then a data phase with the enable strobe E low. In the address phase an external transparent latch captures the upper address bits. In the data phase the same pins carry data. The block returns the read data together with a one-clock done pulse.

The block is clocked at the half-cycle rate, so one clock is one half-cycle of the bus. A no-wait bus cycle is four clocks long: two in the address phase and two in the data phase. Two configuration registers set the data phase length for external targets:
- no wait: 2 data clocks;
- 1.5x: 4 data clocks;
- 2x: 6 data clocks.

Targets in the internal byte range `INT_LO..INT_HI` always get the no-wait length. The same registers can keep E high during internal accesses. The `byte_mode` pin selects the bus width:
- 0 is a 16-bit bus. The middle pins carry the odd byte and the high pins carry the even byte.
- 1 is an 8-bit bus. Only the high pins carry data.

The sequencer has three states: `ST_IDLE`, `ST_ADDR` and `ST_DATA`. Its transitions are:
- `ST_IDLE`→`ST_ADDR` when a request is accepted.
- `ST_ADDR`→`ST_DATA` after the second address clock.
- `ST_DATA`→`ST_ADDR` at the end of the first beat of a two-beat 8-bit access.
- `ST_DATA`→`ST_IDLE` at the end of the last data clock.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, all of the following hold:
  - `e_n`=1, `ale`=0, `busy`=0, `rsp_done`=0, `rd_wr_n`=1 and `bhe_n`=1;
  - both lane output enables are 0;
  - both configuration bits are 0, so external accesses use the 2x length.
- R2: A request is accepted at a clock edge where `req_valid`=1 and `busy`=0. With the no-wait bit set, an external single-beat access asserts `rsp_done` on the 4th clock after the accepting edge. `busy` stays high until the clock after `rsp_done`.
- R3: With the no-wait bit clear, an external single-beat access completes on clock 6 when the wait-select bit is 1, and on clock 8 when it is 0. In both cases the extra clocks lengthen the phase with E low.
- R4: A target whose byte address lies within `INT_LO..INT_HI` completes in 4 clocks per beat, whatever the configuration bits hold. The data lanes are not driven. `rsp_rdata` returns 0, ignoring the pad inputs.
- R5: The address phase lasts two clocks with `ale`=1 and `e_n`=1. During it the pins carry the address: `pad_a_lo`=A[7:0], `pad_mid_o`=A[15:8] and `pad_hi_o`=A[23:16].
- R6: Every data-phase clock has `ale`=0 and `e_n`=0, except as given in R7. E therefore rises only at the end of a beat's last data clock.
- R7: When the strobe-suppress bit is 1, `e_n` stays high throughout internal accesses. External accesses are unaffected.
- R8: 16-bit bus (`byte_mode`=0): data-phase behaviour is as follows.
  - Reads: the high lane carries the even byte (`rsp_rdata[7:0]`) and the middle lane carries the odd byte (`rsp_rdata[15:8]`).
  - Writes: the same lanes drive `req_wdata`, with both output enables set.
- R9: 8-bit bus (`byte_mode`=1): data and beats are handled as follows.
  - The middle lane keeps A[15:8] during the data phase, and data uses the high lane only.
  - With `req_be`=2'b11, two bus cycles run: the even byte first, then the odd byte.
  - `rsp_done` is raised only at the end of the second bus cycle.
- R10: `rd_wr_n` is 1 for reads and 0 for writes throughout the access.
- R11: A0 and `bhe_n` are set as follows.
  - 16-bit bus: A0 is 1 only for `req_be`=2'b10, and `bhe_n` is the inverse of `req_be[1]`.
  - 8-bit bus: A0 marks an odd-byte beat, and `bhe_n` is low exactly on odd-byte beats.
- R12: `rsp_done` is a single-clock pulse. `rsp_rdata` is valid in that clock, and any byte whose enable is clear reads as 0.
- R13: The configuration port works as follows.
  - With `cfg_sel`=0, bit 0 is the no-wait bit and bit 1 is the strobe-suppress bit.
  - With `cfg_sel`=1, bit 0 is the wait-select bit.
  - The values are latched when a request is accepted, so a write in the same clock as the acceptance affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects the 8-bit external bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects configuration register 0 or 1 |
| cfg_wdata | input | 2 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_word | input | 23 | Word address (byte address bits 23:1) |
| req_be | input | 2 | Byte enables, bit 0 for the even byte |
| req_write | input | 1 | 1 for a write |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress; requests are not accepted |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| pad_a_lo | output | 8 | Address bits 7:0 |
| pad_mid_o | output | 8 | Middle lane output (A15:8 / odd data) |
| pad_mid_oe | output | 1 | Middle lane output enable |
| pad_mid_i | input | 8 | Middle lane input |
| pad_hi_o | output | 8 | High lane output (A23:16 / even data) |
| pad_hi_oe | output | 1 | High lane output enable |
| pad_hi_i | input | 8 | High lane input |
| e_n | output | 1 | Enable strobe, low in the data phase |
| ale | output | 1 | Address latch enable |
| rd_wr_n | output | 1 | 1 read, 0 write |
| bhe_n | output | 1 | Low when the odd byte is accessed |

## Verification
Two events can fall in the same clock:
- a configuration write;
- the acceptance of a request, which latches the wait length.

The bench provokes this by raising `cfg_we` and `req_valid` together, after reset has left the 2x setting in force. The accepted access must still take 8 clocks, and the next access must take 4. A second coincidence is the end of the first beat of an 8-bit access. There the held even byte is captured at the same edge that turns the sequencer back to `ST_ADDR`. This is judged by the merged read data arriving with the single done pulse at clock 8.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int ADDR_W = 24;
    localparam int WORD_W = ADDR_W - 1;
    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;
    localparam int CNT_W  = 3;

    localparam logic [CNT_W-1:0] ADDR_CLKS  = 3'd2;
    localparam logic [CNT_W-1:0] DATA_FAST  = 3'd2;
    localparam logic [CNT_W-1:0] DATA_HALF  = 3'd4;
    localparam logic [CNT_W-1:0] DATA_SLOW  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_st_e;
endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [1:0] cfg_wdata,
    output logic       nowait,
    output logic       suppress,
    output logic       wsel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nowait   <= 1'b0;
            suppress <= 1'b0;
            wsel     <= 1'b0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                nowait   <= cfg_wdata[0];
                suppress <= cfg_wdata[1];
            end else begin
                wsel     <= cfg_wdata[0];
            end
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INT_LO = 24'h000000,
    parameter logic [ADDR_W-1:0] INT_HI = 24'h00087F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    input  logic [1:0]        req_be,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              byte_mode,
    input  logic              nowait,
    input  logic              wsel,
    output bus_st_e           st,
    output logic              busy,
    output logic [WORD_W-1:0] word_q,
    output logic [1:0]        be_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] wd_q,
    output logic              int_q,
    output logic              mode8_q,
    output logic              beat1_q,
    output logic              done,
    output logic              cap_lo
);
    bus_st_e           st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_sel;
    logic              two_q, accept, last, more, hit_int;
    logic [ADDR_W-1:0] req_byte;

    assign req_byte = {req_word, 1'b0};
    assign hit_int  = (req_byte - INT_LO) <= (INT_HI - INT_LO);
    assign accept   = (st_q == ST_IDLE) && req_valid;
    assign last     = (st_q == ST_DATA) && (cnt_q == len_q - 3'd1);
    assign more     = two_q && !beat1_q;

    always_comb begin
        if (hit_int || nowait) len_sel = DATA_FAST;
        else if (wsel)         len_sel = DATA_HALF;
        else                   len_sel = DATA_SLOW;
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) begin
                st_d  = ST_ADDR;
                cnt_d = '0;
            end
            ST_ADDR: if (cnt_q == ADDR_CLKS - 3'd1) begin
                st_d  = ST_DATA;
                cnt_d = '0;
            end else cnt_d = cnt_q + 3'd1;
            ST_DATA: if (last) begin
                st_d  = more ? ST_ADDR : ST_IDLE;
                cnt_d = '0;
            end else cnt_d = cnt_q + 3'd1;
            default: st_d = ST_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= DATA_FAST;
            word_q  <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
            wd_q    <= '0;
            int_q   <= 1'b0;
            mode8_q <= 1'b0;
            two_q   <= 1'b0;
            beat1_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (accept) begin
                word_q  <= req_word;
                be_q    <= req_be;
                wr_q    <= req_write;
                wd_q    <= req_wdata;
                int_q   <= hit_int;
                mode8_q <= byte_mode;
                len_q   <= len_sel;
                two_q   <= byte_mode && (req_be == 2'b11);
                beat1_q <= 1'b0;
            end else if (last && more) begin
                beat1_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        st     = st_q;
        busy   = (st_q != ST_IDLE);
        done   = last && !more;
        cap_lo = last && more;
    end

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);
    a_r3_count_below_length: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA) |-> (cnt_q < len_q));
    a_r9_done_after_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (done && two_q) |-> beat1_q);
    a_r4_internal_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && int_q) |-> (len_q == DATA_FAST));
endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_st_e           st,
    input  logic [WORD_W-1:0] word_q,
    input  logic [1:0]        be_q,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] wd_q,
    input  logic              int_q,
    input  logic              mode8_q,
    input  logic              beat1_q,
    input  logic              suppress,
    input  logic              done,
    input  logic              cap_lo,
    input  logic [LANE_W-1:0] pad_mid_i,
    input  logic [LANE_W-1:0] pad_hi_i,
    output logic [LANE_W-1:0] pad_a_lo,
    output logic [LANE_W-1:0] pad_mid_o,
    output logic              pad_mid_oe,
    output logic [LANE_W-1:0] pad_hi_o,
    output logic              pad_hi_oe,
    output logic              e_n,
    output logic              ale,
    output logic              rd_wr_n,
    output logic              bhe_n,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              a0, drive_data;
    logic [ADDR_W-1:0] addr;
    logic [LANE_W-1:0] held_q, beat_byte;
    logic [DATA_W-1:0] merged;

    assign a0         = (mode8_q && beat1_q) || (be_q == 2'b10);
    assign addr       = {word_q, a0};
    assign drive_data = wr_q && !int_q;
    assign beat_byte  = a0 ? wd_q[DATA_W-1:LANE_W] : wd_q[LANE_W-1:0];

    always_comb begin
        pad_a_lo   = '0;
        pad_mid_o  = '0;
        pad_hi_o   = '0;
        pad_mid_oe = 1'b0;
        pad_hi_oe  = 1'b0;
        e_n        = 1'b1;
        ale        = 1'b0;
        rd_wr_n    = 1'b1;
        bhe_n      = 1'b1;
        unique case (st)
            ST_IDLE: ;
            ST_ADDR: begin
                pad_a_lo   = addr[7:0];
                pad_mid_o  = addr[15:8];
                pad_hi_o   = addr[23:16];
                pad_mid_oe = 1'b1;
                pad_hi_oe  = 1'b1;
                ale        = 1'b1;
                rd_wr_n    = !wr_q;
                bhe_n      = mode8_q ? !a0 : !be_q[1];
            end
            ST_DATA: begin
                pad_a_lo = addr[7:0];
                if (mode8_q) begin
                    pad_mid_o  = addr[15:8];
                    pad_mid_oe = 1'b1;
                    pad_hi_o   = drive_data ? beat_byte : '0;
                end else begin
                    pad_mid_o  = drive_data ? wd_q[DATA_W-1:LANE_W] : '0;
                    pad_mid_oe = drive_data;
                    pad_hi_o   = drive_data ? wd_q[LANE_W-1:0] : '0;
                end
                pad_hi_oe = drive_data;
                e_n       = int_q && suppress;
                rd_wr_n   = !wr_q;
                bhe_n     = mode8_q ? !a0 : !be_q[1];
            end
            default: ;
        endcase
    end

    // even byte of a two-beat access, taken as E rises on the first beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= '0;
        else if (cap_lo) held_q <= int_q ? '0 : pad_hi_i;
    end

    always_comb begin
        if (int_q) merged = '0;
        else if (mode8_q) begin
            unique case (be_q)
                2'b11:   merged = {pad_hi_i, held_q};
                2'b10:   merged = {pad_hi_i, {LANE_W{1'b0}}};
                2'b01:   merged = {{LANE_W{1'b0}}, pad_hi_i};
                default: merged = '0;
            endcase
        end else begin
            merged = {be_q[1] ? pad_mid_i : {LANE_W{1'b0}},
                      be_q[0] ? pad_hi_i  : {LANE_W{1'b0}}};
        end
        rsp_rdata = done ? merged : '0;
    end

    a_r6_ale_e_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !e_n));
    a_r4_internal_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && int_q) |-> (!pad_hi_oe && (mode8_q || !pad_mid_oe)));
    a_r9_mid_holds_address: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && mode8_q) |-> (pad_mid_oe && pad_mid_o == word_q[14:7]));
    a_r12_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rsp_rdata == '0));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INT_LO = 24'h000000,
    parameter logic [ADDR_W-1:0] INT_HI = 24'h00087F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [1:0]        cfg_wdata,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    input  logic [1:0]        req_be,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [LANE_W-1:0] pad_a_lo,
    output logic [LANE_W-1:0] pad_mid_o,
    output logic              pad_mid_oe,
    input  logic [LANE_W-1:0] pad_mid_i,
    output logic [LANE_W-1:0] pad_hi_o,
    output logic              pad_hi_oe,
    input  logic [LANE_W-1:0] pad_hi_i,
    output logic              e_n,
    output logic              ale,
    output logic              rd_wr_n,
    output logic              bhe_n
);
    logic              nowait, suppress, wsel;
    bus_st_e           st;
    logic [WORD_W-1:0] word_q;
    logic [1:0]        be_q;
    logic              wr_q, int_q, mode8_q, beat1_q, cap_lo;
    logic [DATA_W-1:0] wd_q;

    xbus_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .nowait(nowait), .suppress(suppress), .wsel(wsel)
    );

    xbus_seq #(.INT_LO(INT_LO), .INT_HI(INT_HI)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
        .byte_mode(byte_mode), .nowait(nowait), .wsel(wsel), .st(st),
        .busy(busy), .word_q(word_q), .be_q(be_q), .wr_q(wr_q), .wd_q(wd_q),
        .int_q(int_q), .mode8_q(mode8_q), .beat1_q(beat1_q),
        .done(rsp_done), .cap_lo(cap_lo)
    );

    xbus_lanes u_lanes (
        .clk(clk), .rst_n(rst_n), .st(st), .word_q(word_q), .be_q(be_q),
        .wr_q(wr_q), .wd_q(wd_q), .int_q(int_q), .mode8_q(mode8_q),
        .beat1_q(beat1_q), .suppress(suppress), .done(rsp_done),
        .cap_lo(cap_lo), .pad_mid_i(pad_mid_i), .pad_hi_i(pad_hi_i),
        .pad_a_lo(pad_a_lo), .pad_mid_o(pad_mid_o), .pad_mid_oe(pad_mid_oe),
        .pad_hi_o(pad_hi_o), .pad_hi_oe(pad_hi_oe), .e_n(e_n), .ale(ale),
        .rd_wr_n(rd_wr_n), .bhe_n(bhe_n), .rsp_rdata(rsp_rdata)
    );

    a_r10_direction_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> $stable(rd_wr_n));
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [22:0] word;
        logic [1:0]  be;
        logic        wr;
        logic [15:0] wd;
        logic        mode;
        logic        nowait;
        logic        wsel;
        logic        supp;
        logic [4:0]  lat;
        logic [4:0]  elow;
    } vec_t;

    localparam logic [22:0] EXT_W = 23'h091A2B;  // byte address 0x123456
    localparam logic [22:0] INT_W = 23'h000080;  // byte address 0x000100
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{EXT_W, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd4,  5'd2},
        '{EXT_W, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 5'd6,  5'd4},
        '{EXT_W, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd8,  5'd6},
        '{EXT_W, 2'b11, 1'b1, 16'hBEEF, 1'b0, 1'b1, 1'b0, 1'b0, 5'd4,  5'd2},
        '{EXT_W, 2'b10, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd4,  5'd2},
        '{EXT_W, 2'b01, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b0, 5'd6,  5'd4},
        '{INT_W, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4,  5'd2},
        '{INT_W, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4,  5'd0},
        '{EXT_W, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 5'd4,  5'd2},
        '{EXT_W, 2'b11, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 5'd8,  5'd4},
        '{EXT_W, 2'b11, 1'b1, 16'hA55A, 1'b1, 1'b0, 1'b1, 1'b0, 5'd12, 5'd8},
        '{EXT_W, 2'b10, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 5'd4,  5'd2},
        '{EXT_W, 2'b01, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd8,  5'd6},
        '{INT_W, 2'b11, 1'b1, 16'h7777, 1'b1, 1'b0, 1'b0, 1'b1, 5'd8,  5'd0}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        byte_mode = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [22:0] req_word = '0, cur_word = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_done, pad_mid_oe, pad_hi_oe, e_n, ale, rd_wr_n, bhe_n;
    logic [15:0] rsp_rdata;
    logic [7:0]  pad_a_lo, pad_mid_o, pad_hi_o, pad_mid_i, pad_hi_i;
    int checks = 0, failures = 0;

    // measured results of one access
    int   m_lat, m_elow;
    logic m_addr_ok, m_ale_ok, m_rw, m_bhe, m_hi_oe, m_busy;
    logic [15:0] m_rd;
    logic [7:0]  m_hi, m_mid;

    xbus_ctrl uut (.*);

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // external memory model on the lanes
    always_comb begin
        if (byte_mode) begin
            pad_hi_i  = mem_byte({cur_word, pad_a_lo[0]});
            pad_mid_i = 8'hEE;
        end else begin
            pad_hi_i  = mem_byte({cur_word, 1'b0});
            pad_mid_i = mem_byte({cur_word, 1'b1});
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_access(input logic [22:0] w, input logic [1:0] be,
                              input logic wr, input logic [15:0] wd, input logic mode);
        logic [23:0] a_exp;
        @(negedge clk);
        req_valid = 1'b1; req_word = w; req_be = be; req_write = wr;
        req_wdata = wd; byte_mode = mode; cur_word = w;
        a_exp = {w, be == 2'b10};
        @(negedge clk);
        req_valid = 1'b0;
        m_lat = 0; m_elow = 0; m_addr_ok = 1'b1; m_ale_ok = 1'b1; m_busy = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            if (k <= 2)
                if (!(ale && e_n && pad_a_lo == a_exp[7:0] && pad_mid_o == a_exp[15:8]
                      && pad_hi_o == a_exp[23:16] && pad_mid_oe && pad_hi_oe))
                    m_addr_ok = 1'b0;
            if (!e_n) begin
                m_elow++;
                if (ale) m_ale_ok = 1'b0;
            end
            if (!busy) m_busy = 1'b0;
            if (rsp_done) begin
                m_lat = k; m_rd = rsp_rdata; m_rw = rd_wr_n; m_bhe = bhe_n;
                m_hi = pad_hi_o; m_mid = pad_mid_o; m_hi_oe = pad_hi_oe;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [22:0] w, input logic [1:0] be,
                                           input logic internal);
        logic [7:0] ev, od;
        ev = mem_byte({w, 1'b0});
        od = mem_byte({w, 1'b1});
        if (internal) return 16'h0;
        return {be[1] ? od : 8'h00, be[0] ? ev : 8'h00};
    endfunction

    initial begin
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle state after reset
        chk(e_n && !ale && !busy && !rsp_done && rd_wr_n && bhe_n && !pad_hi_oe && !pad_mid_oe,
            "R1 reset pins", {e_n, ale, busy, rsp_done}, 4'b1000);
        rst_n = 1'b1;
        // R1: default timing is 2x
        run_access(EXT_W, 2'b11, 1'b0, 16'h0, 1'b0);
        chk(m_lat == 8, "R1 reset 2x length", m_lat, 8);
        // R13: config write coinciding with acceptance
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 2'b01;
        req_valid = 1'b1; req_word = EXT_W; req_be = 2'b11; req_write = 1'b0;
        byte_mode = 1'b0; cur_word = EXT_W;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_lat = 0;
        for (int k = 1; k <= 40; k++) begin
            if (rsp_done) begin m_lat = k; break; end
            @(negedge clk);
        end
        chk(m_lat == 8, "R13 same-clock write not applied", m_lat, 8);
        run_access(EXT_W, 2'b11, 1'b0, 16'h0, 1'b0);
        chk(m_lat == 4, "R13 write applied next", m_lat, 4);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic internal, last_odd;
            logic [7:0] exp_hi;
            v = VECS[i];
            internal = ({v.word, 1'b0} <= 24'h00087F);
            cfg_write(1'b0, {v.supp, v.nowait});
            cfg_write(1'b1, {1'b0, v.wsel});
            run_access(v.word, v.be, v.wr, v.wd, v.mode);
            chk(m_lat == int'(v.lat), $sformatf("R2 R3 R4 R9 length v%0d", i), m_lat, int'(v.lat));
            chk(m_elow == int'(v.elow), $sformatf("R6 R7 E low clocks v%0d", i), m_elow, int'(v.elow));
            chk(m_addr_ok, $sformatf("R5 address phase v%0d", i), m_addr_ok, 1);
            chk(m_ale_ok, $sformatf("R6 ale low with E v%0d", i), m_ale_ok, 1);
            chk(m_busy, $sformatf("R2 busy during access v%0d", i), m_busy, 1);
            chk(m_rw == !v.wr, $sformatf("R10 direction v%0d", i), m_rw, !v.wr);
            last_odd = v.mode ? (v.be != 2'b01) : (v.be == 2'b10);
            chk(m_bhe == (v.mode ? !last_odd : !v.be[1]),
                $sformatf("R11 bhe v%0d", i), m_bhe, v.mode ? !last_odd : !v.be[1]);
            if (!v.wr)
                chk(m_rd == exp_rd(v.word, v.be, internal),
                    $sformatf("R4 R8 R9 R12 read data v%0d", i), m_rd, exp_rd(v.word, v.be, internal));
            else if (internal)
                chk(!m_hi_oe, $sformatf("R4 lanes quiet v%0d", i), m_hi_oe, 0);
            else begin
                exp_hi = v.mode ? (last_odd ? v.wd[15:8] : v.wd[7:0]) : v.wd[7:0];
                chk(m_hi_oe && m_hi == exp_hi, $sformatf("R8 R9 high lane v%0d", i), m_hi, exp_hi);
                chk(m_mid == (v.mode ? v.word[14:7] : v.wd[15:8]),
                    $sformatf("R8 R9 middle lane v%0d", i), m_mid, v.mode ? v.word[14:7] : v.wd[15:8]);
            end
            @(negedge clk);
            chk(!rsp_done && rsp_rdata == 16'h0, $sformatf("R12 done pulse v%0d", i), rsp_done, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule